// File: doc/BRIEF.md
# SCSI Initiator Register Interface

This block is the host-facing register file and command decoder of a small SCSI initiator. The host reaches sixteen byte registers through a byte address. Writes land in a write bank and reads come from a separate read bank, so one address can hold a value written by the host and a different value reported by the controller. The read bank holds a 16-bit transfer count, the status, interrupt-cause and sequence-step registers, and a revision byte. A 16-byte FIFO sits behind the data register.

A byte written to the command register is decoded into updates of the status, interrupt-cause, sequence-step and count registers. Depending on the opcode it can also raise the interrupt line or emit a one-cycle transfer-start strobe toward the data mover. The target-presence vector is an input. It stands in for the bus-side selection outcome, so selection commands complete in the cycle after they are written. Reading the interrupt-cause register acknowledges the interrupt.

Top module: `scsi_regif`

## Requirements
- R1: The register index is (host_addr AND 0x3F) >> 2, so address bits 1:0 and 7:6 do not affect which of the 16 registers is reached.
- R2: After rst_n low, or one cycle after command opcode 0x02 (chip reset), every read register is 0x00 except index 14, which reads 0x04. Every write register is 0x00, the FIFO is empty and irq is low.
- R3: A host write changes only the write bank. Reading an index that the controller does not update (0, 1, 4, 14, 15) returns the read-bank value, not the byte that was written.
- R4: A recognised command written with bit 7 (DMA flag) set copies write registers 0 and 1 into read registers 0 (count low) and 1 (count high). Without the flag the count registers are unchanged.
- R5: Writing index 2 pushes a byte into the 16-deep FIFO. Reading index 2 pops bytes in arrival order. When the FIFO is empty, the read returns the last byte popped.
- R6: A push into a full FIFO and a pop from an empty FIFO are ignored. Either one pulses fifo_drop high for the cycle after the access.
- R7: A read of index 5 returns the interrupt cause, clears status bits 7 (interrupt), 6 (gross error) and 5 (parity error), and drops irq.
- R8: Opcode 0x03 (bus reset) sets the interrupt cause to 0x80. It raises irq only when bit 6 of write register 8 is 0.
- R9: Opcode 0x01 (flush) empties the FIFO and sets the interrupt cause to 0x08 (function complete). Opcode 0x12 (message accepted) sets it to 0x20 (disconnect).
- R10: Opcode 0x42 (select with attention) or 0x43 (select with attention and stop) addresses target write-register-4 bits 2:0. If that target is present, status becomes 0x90 for 0x42 or 0x92 for 0x43 (interrupt, terminal count bit 4, command phase 3'b010 for the stop form). The interrupt cause becomes 0x18, sequence step (index 6) becomes 0x04, and irq rises.
- R11: A selection of an absent target sets status to 0x80, interrupt cause to 0x20 and sequence step to 0x00, and raises irq.
- R12: Every write to the command register (index 3) clears status bit 4 (terminal count), unless a successful selection sets it again.
- R13: Opcode 0x10 (transfer information) pulses xfer_start high for exactly the cycle after the command write.
- R14: An opcode outside the set listed above leaves count, interrupt cause, sequence step, FIFO and irq unchanged, even when bit 7 is set. Only the terminal-count clear of R12 applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 8 | Host byte address |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe, ignored when host_wr is high |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid the cycle after host_rd |
| tgt_present | input | 8 | One bit per target ID, 1 if the target answers selection |
| irq | output | 1 | Interrupt line |
| xfer_start | output | 1 | One-cycle strobe starting a data transfer |
| fifo_drop | output | 1 | One-cycle flag for an ignored FIFO push or pop |

## Verification
The bench first writes the count registers, then reads them before and after a DMA-flagged command. A design that merged the banks, or reloaded on every command, would return the written bytes too early. It pushes seventeen bytes and pops past empty. An off-by-one depth would accept the extra byte, or a bad pointer would repeat or skip data, and either fault shows up in the popped sequence or in fifo_drop. It reads status before and after the interrupt-cause read, and issues bus reset with the mask bit both set and clear, to catch a clear that hits the wrong bits or an irq that ignores the mask. It also sends an unknown opcode that has the DMA flag set, while irq and a non-zero cause are pending; a decoder that does not filter unknown opcodes would reload the count or disturb the pending interrupt.

// File: rtl/scsi_regif_pkg.sv
package scsi_regif_pkg;

  localparam int NUM_REGS = 16;
  localparam int IDX_W    = 4;
  localparam int NUM_TGT  = 8;

  localparam logic [IDX_W-1:0] IDX_CNT_LO = 4'd0;
  localparam logic [IDX_W-1:0] IDX_CNT_HI = 4'd1;
  localparam logic [IDX_W-1:0] IDX_FIFO   = 4'd2;
  localparam logic [IDX_W-1:0] IDX_CMD    = 4'd3;
  localparam logic [IDX_W-1:0] IDX_STAT   = 4'd4;
  localparam logic [IDX_W-1:0] IDX_CAUSE  = 4'd5;
  localparam logic [IDX_W-1:0] IDX_STEP   = 4'd6;
  localparam logic [IDX_W-1:0] IDX_CFG    = 4'd8;
  localparam logic [IDX_W-1:0] IDX_REV    = 4'd14;

  localparam logic [7:0] REV_ID = 8'h04;

  // status bits
  localparam logic [7:0] ST_INT   = 8'h80;
  localparam logic [7:0] ST_GERR  = 8'h40;
  localparam logic [7:0] ST_PERR  = 8'h20;
  localparam logic [7:0] ST_TCNT  = 8'h10;
  localparam logic [7:0] ST_PH_CMD = 8'h02;

  // interrupt cause bits
  localparam logic [7:0] CA_BUSRST = 8'h80;
  localparam logic [7:0] CA_DISC   = 8'h20;
  localparam logic [7:0] CA_SVC    = 8'h10;
  localparam logic [7:0] CA_DONE   = 8'h08;

  localparam logic [7:0] STEP_DONE = 8'h04;

  // opcodes (bits 6:0 of the command byte)
  localparam logic [6:0] OP_NOP      = 7'h00;
  localparam logic [6:0] OP_FLUSH    = 7'h01;
  localparam logic [6:0] OP_CHIPRST  = 7'h02;
  localparam logic [6:0] OP_BUSRST   = 7'h03;
  localparam logic [6:0] OP_XFER     = 7'h10;
  localparam logic [6:0] OP_MSGACC   = 7'h12;
  localparam logic [6:0] OP_SEL      = 7'h42;
  localparam logic [6:0] OP_SELSTOP  = 7'h43;

  typedef struct packed {
    logic dma;
    logic known;
    logic flush;
    logic chip_rst;
    logic bus_rst;
    logic xfer;
    logic msg_acc;
    logic sel;
    logic sel_stop;
  } cmd_ev_t;

  function automatic logic [IDX_W-1:0] reg_index(input logic [7:0] addr);
    logic [7:0] t;
    t = (addr & 8'h3F) >> 2;
    return t[IDX_W-1:0];
  endfunction

  function automatic logic [7:0] rd_reset_val(input logic [IDX_W-1:0] i);
    return (i == IDX_REV) ? REV_ID : 8'h00;
  endfunction

  function automatic logic [7:0] sel_status(input logic stop_form);
    return ST_INT | ST_TCNT | (stop_form ? ST_PH_CMD : 8'h00);
  endfunction

  function automatic logic [7:0] ack_status(input logic [7:0] st);
    return st & ~(ST_INT | ST_GERR | ST_PERR);
  endfunction

endpackage

// File: rtl/scsi_regif_cmd_dec.sv
module scsi_regif_cmd_dec
  import scsi_regif_pkg::*;
(
  input  logic       valid,
  input  logic [7:0] code,
  output cmd_ev_t    ev
);

  always_comb begin
    ev = '0;
    if (valid) begin
      ev.dma   = code[7];
      ev.known = 1'b1;
      case (code[6:0])
        OP_NOP:     ;
        OP_FLUSH:   ev.flush    = 1'b1;
        OP_CHIPRST: ev.chip_rst = 1'b1;
        OP_BUSRST:  ev.bus_rst  = 1'b1;
        OP_XFER:    ev.xfer     = 1'b1;
        OP_MSGACC:  ev.msg_acc  = 1'b1;
        OP_SEL:     ev.sel      = 1'b1;
        OP_SELSTOP: ev.sel_stop = 1'b1;
        default:    ev.known    = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/scsi_regif_fifo.sv
module scsi_regif_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic             drop
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;
  logic             push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      drop  <= 1'b0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      drop  <= 1'b0;
    end else begin
      if (push_ok) wptr <= ptr_next(wptr);
      if (pop_ok)  rptr <= ptr_next(rptr);
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
      drop  <= (push && full) || (pop && empty);
    end
  end

  // R6
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R6
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> ($stable(count) && drop));

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !clr) |=> ($stable(count) && drop));

endmodule

// File: rtl/scsi_regif.sv
module scsi_regif
  import scsi_regif_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  input  logic [NUM_TGT-1:0] tgt_present,
  output logic               irq,
  output logic               xfer_start,
  output logic               fifo_drop
);

  localparam int TGT_W = $clog2(NUM_TGT);

  logic [IDX_W-1:0] idx;
  logic             wr_fire, rd_fire, cmd_wr;
  cmd_ev_t          ev;

  assign idx     = reg_index(host_addr);
  assign wr_fire = host_wr;
  assign rd_fire = host_rd && !host_wr;
  assign cmd_wr  = wr_fire && (idx == IDX_CMD);

  scsi_regif_cmd_dec u_dec (
    .valid (cmd_wr),
    .code  (host_wdata),
    .ev    (ev)
  );

  // write bank
  logic [7:0] wbank [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wbank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  wbank[g] <= 8'h00;
      else if (ev.chip_rst)                        wbank[g] <= 8'h00;
      else if (wr_fire && idx == IDX_W'(g))        wbank[g] <= host_wdata;
    end
  end

  // named events for checking
  logic [TGT_W-1:0] tgt_id;
  logic             tgt_here, sel_ev, bus_irq_ok, irq_raise_ev, cause_read_ev;
  logic             fifo_push, fifo_pop, fifo_clr;
  logic [7:0]       fifo_dout;
  logic             fifo_empty, fifo_full;

  assign tgt_id        = wbank[IDX_STAT][TGT_W-1:0];
  assign tgt_here      = tgt_present[tgt_id];
  assign sel_ev        = ev.sel || ev.sel_stop;
  assign bus_irq_ok    = !wbank[IDX_CFG][6];
  assign irq_raise_ev  = (ev.bus_rst && bus_irq_ok) || sel_ev;
  assign cause_read_ev = rd_fire && (idx == IDX_CAUSE);
  assign fifo_push     = wr_fire && (idx == IDX_FIFO);
  assign fifo_pop      = rd_fire && (idx == IDX_FIFO);
  assign fifo_clr      = ev.flush || ev.chip_rst;

  scsi_regif_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_clr),
    .push  (fifo_push),
    .pop   (fifo_pop),
    .din   (host_wdata),
    .dout  (fifo_dout),
    .empty (fifo_empty),
    .full  (fifo_full),
    .drop  (fifo_drop)
  );

  // read bank
  logic [7:0] rbank [NUM_REGS];
  logic [7:0] rnext [NUM_REGS];

  always_comb begin
    rnext = rbank;
    if (cmd_wr) rnext[IDX_STAT] = rbank[IDX_STAT] & ~ST_TCNT;
    if (ev.known && ev.dma) begin
      rnext[IDX_CNT_LO] = wbank[IDX_CNT_LO];
      rnext[IDX_CNT_HI] = wbank[IDX_CNT_HI];
    end
    if (ev.flush)   rnext[IDX_CAUSE] = CA_DONE;
    if (ev.bus_rst) rnext[IDX_CAUSE] = CA_BUSRST;
    if (ev.msg_acc) rnext[IDX_CAUSE] = CA_DISC;
    if (sel_ev) begin
      if (tgt_here) begin
        rnext[IDX_STAT]  = sel_status(ev.sel_stop);
        rnext[IDX_CAUSE] = CA_SVC | CA_DONE;
        rnext[IDX_STEP]  = STEP_DONE;
      end else begin
        rnext[IDX_STAT]  = ST_INT;
        rnext[IDX_CAUSE] = CA_DISC;
        rnext[IDX_STEP]  = 8'h00;
      end
    end
    if (fifo_pop && !fifo_empty) rnext[IDX_FIFO] = fifo_dout;
    if (cause_read_ev) rnext[IDX_STAT] = ack_status(rbank[IDX_STAT]);
    if (ev.chip_rst) begin
      for (int i = 0; i < NUM_REGS; i++) rnext[i] = rd_reset_val(IDX_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) rbank[i] <= rd_reset_val(IDX_W'(i));
    end else begin
      rbank <= rnext;
    end
  end

  // host read data, irq, transfer strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= 8'h00;
      irq        <= 1'b0;
      xfer_start <= 1'b0;
    end else begin
      if (rd_fire) begin
        if (idx == IDX_FIFO && !fifo_empty) host_rdata <= fifo_dout;
        else                                host_rdata <= rbank[idx];
      end
      if (ev.chip_rst)        irq <= 1'b0;
      else if (irq_raise_ev)  irq <= 1'b1;
      else if (cause_read_ev) irq <= 1'b0;
      xfer_start <= ev.xfer;
    end
  end

  // R7
  cause_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_read_ev |=> (!irq && (rbank[IDX_STAT] & (ST_INT | ST_GERR | ST_PERR)) == 8'h00));

  // R8
  bus_rst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.bus_rst && !bus_irq_ok && !irq) |=> !irq);

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_raise_ev));

  // R12
  tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !sel_ev) |=> !rbank[IDX_STAT][4]);

  // R13
  xfer_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> $past(ev.xfer));

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.known && ev.dma && !ev.chip_rst) |=> (rbank[IDX_CNT_LO] == $past(wbank[IDX_CNT_LO])));

  // R14
  unknown_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !ev.known) |=> $stable(irq));

endmodule

// File: tb/scsi_regif_bench.sv
module scsi_regif_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] host_addr = 8'h00;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic [7:0] tgt_present = 8'b0000_0101;
  logic       irq, xfer_start, fifo_drop;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  scsi_regif u_scsi_regif (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .tgt_present (tgt_present),
    .irq         (irq),
    .xfer_start  (xfer_start),
    .fifo_drop   (fifo_drop)
  );

  function automatic logic [7:0] ra(input int i);
    return 8'(i << 2);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    exp_q.push_back(exp);
    tag_q.push_back(req);
  endtask

  // monitor: compares read data one step after the driver queues it
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, host_rdata, e);
      end
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got 0x00 expected 0x01");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 irq", {7'd0, irq}, 8'h00);
    chk("R2 xfer_start", {7'd0, xfer_start}, 8'h00);
    rd(ra(14), 8'h04, "R2 revision");
    rd(8'h78, 8'h04, "R1 upper bits masked");
    rd(8'h3B, 8'h04, "R1 low bits ignored");
    rd(ra(5), 8'h00, "R2 cause");
    rd(ra(4), 8'h00, "R2 status");

    // R3 split banks
    wr(ra(0), 8'h34);
    wr(ra(1), 8'h12);
    rd(ra(0), 8'h00, "R3 count lo");
    rd(ra(1), 8'h00, "R3 count hi");
    wr(ra(15), 8'hAA);
    rd(ra(15), 8'h00, "R3 idx15");
    wr(ra(14), 8'h77);
    rd(ra(14), 8'h04, "R3 revision kept");

    // R4 reload only with DMA flag
    wr(ra(3), 8'h00);
    rd(ra(0), 8'h00, "R4 no reload");
    wr(ra(3), 8'h80);
    rd(ra(0), 8'h34, "R4 reload lo");
    rd(ra(1), 8'h12, "R4 reload hi");

    // R5 / R6 FIFO
    wr(ra(2), 8'hA1);
    wr(ra(2), 8'hA2);
    wr(ra(2), 8'hA3);
    chk("R6 no drop on push", {7'd0, fifo_drop}, 8'h00);
    rd(ra(2), 8'hA1, "R5 pop 1");
    rd(ra(2), 8'hA2, "R5 pop 2");
    rd(ra(2), 8'hA3, "R5 pop 3");
    chk("R6 no drop on pop", {7'd0, fifo_drop}, 8'h00);
    rd(ra(2), 8'hA3, "R5 empty returns last");
    chk("R6 underflow flag", {7'd0, fifo_drop}, 8'h01);
    for (int i = 0; i < 16; i++) wr(ra(2), 8'(8'h10 + i));
    chk("R6 16th push accepted", {7'd0, fifo_drop}, 8'h00);
    wr(ra(2), 8'hEE);
    chk("R6 overflow flag", {7'd0, fifo_drop}, 8'h01);
    for (int i = 0; i < 16; i++) rd(ra(2), 8'(8'h10 + i), "R5 full order");
    rd(ra(2), 8'h1F, "R6 overflow byte dropped");
    chk("R6 empty after 16", {7'd0, fifo_drop}, 8'h01);

    // R9 flush
    wr(ra(2), 8'h5A);
    wr(ra(3), 8'h01);
    rd(ra(5), 8'h08, "R9 flush cause");
    rd(ra(2), 8'h1F, "R9 flush emptied");
    chk("R9 flush emptied flag", {7'd0, fifo_drop}, 8'h01);

    // R8 bus reset, R7 ack
    wr(ra(3), 8'h03);
    chk("R8 irq raised", {7'd0, irq}, 8'h01);
    rd(ra(5), 8'h80, "R8 cause");
    chk("R7 irq cleared", {7'd0, irq}, 8'h00);
    wr(ra(8), 8'h40);
    wr(ra(3), 8'h03);
    chk("R8 irq masked", {7'd0, irq}, 8'h00);
    rd(ra(5), 8'h80, "R8 cause masked");

    // R10 selection with stop, present target 2
    wr(ra(4), 8'h02);
    rd(ra(4), 8'h00, "R3 status not written");
    wr(ra(3), 8'h43);
    chk("R10 irq", {7'd0, irq}, 8'h01);
    rd(ra(4), 8'h92, "R10 stop status");
    rd(ra(6), 8'h04, "R10 step");
    rd(ra(5), 8'h18, "R10 cause");
    chk("R7 irq ack", {7'd0, irq}, 8'h00);
    rd(ra(4), 8'h12, "R7 status bit7 cleared");

    // R11 absent target 1
    wr(ra(4), 8'h01);
    wr(ra(3), 8'h42);
    chk("R11 irq", {7'd0, irq}, 8'h01);
    rd(ra(4), 8'h80, "R11 status");
    rd(ra(6), 8'h00, "R11 step");
    rd(ra(5), 8'h20, "R11 cause");
    chk("R11 irq ack", {7'd0, irq}, 8'h00);

    // R10 plain selection, target 0
    wr(ra(4), 8'h00);
    wr(ra(3), 8'h42);
    rd(ra(4), 8'h90, "R10 plain status");
    rd(ra(5), 8'h18, "R10 plain cause");
    rd(ra(4), 8'h10, "R7 ack keeps TC");

    // R12
    wr(ra(3), 8'h00);
    rd(ra(4), 8'h00, "R12 TC cleared");

    // R13 transfer with DMA reload
    wr(ra(0), 8'h55);
    wr(ra(3), 8'h90);
    chk("R13 xfer pulse", {7'd0, xfer_start}, 8'h01);
    @(negedge clk);
    chk("R13 pulse one cycle", {7'd0, xfer_start}, 8'h00);
    rd(ra(0), 8'h55, "R4 reload on transfer");
    wr(ra(3), 8'h00);
    chk("R13 no pulse on nop", {7'd0, xfer_start}, 8'h00);

    // R9 message accepted
    wr(ra(3), 8'h12);
    rd(ra(5), 8'h20, "R9 msg accepted cause");

    // R14 unknown opcode with DMA flag
    wr(ra(3), 8'h43);
    wr(ra(0), 8'h99);
    wr(ra(3), 8'hFF);
    chk("R14 irq kept", {7'd0, irq}, 8'h01);
    rd(ra(4), 8'h82, "R14 only TC cleared");
    rd(ra(0), 8'h55, "R14 no reload");
    rd(ra(6), 8'h04, "R14 step kept");
    rd(ra(5), 8'h18, "R14 cause kept");

    // R2 chip reset command
    wr(ra(2), 8'h66);
    wr(ra(3), 8'h03);
    chk("R8 masked before chip reset", {7'd0, irq}, 8'h00);
    wr(ra(3), 8'h43);
    wr(ra(3), 8'h02);
    chk("R2 chip reset irq", {7'd0, irq}, 8'h00);
    rd(ra(0), 8'h00, "R2 chip reset count");
    rd(ra(14), 8'h04, "R2 chip reset revision");
    rd(ra(5), 8'h00, "R2 chip reset cause");
    rd(ra(2), 8'h00, "R2 chip reset fifo");
    chk("R2 fifo empty", {7'd0, fifo_drop}, 8'h01);
    wr(ra(3), 8'h03);
    chk("R2 config cleared", {7'd0, irq}, 8'h01);
    rd(ra(5), 8'h80, "R2 bus reset after chip reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule